// File: doc/BRIEF.md
# Selectable FP32 Activation Stage

This block is a registered post-processing stage for a matrix engine's result path. Each cycle it can accept one single-precision value, a valid flag and a 3-bit function code. One clock later it presents the processed value together with a delayed valid. It applies one of three functions to one result column at a time:

- an exact passthrough,
- a rectifier that clamps negatives to zero,
- a GeLU approximation read from a constant 256-entry table that spans inputs from -4 up to, but not including, +4.

The function code is decoded into three function modes: `FN_PASS`, `FN_RELU` and `FN_GELU`. Under `FN_GELU`, each input is sorted into one of four range classes. `RG_INSIDE` reads the table. `RG_ABOVE` passes the input through. `RG_BELOW` forces +0.0. `RG_NAN` passes the input through. The stage holds no sequential control, so there are no state transitions; the only storage is the output register and the valid flop. The table index is formed straight from the exponent and mantissa fields with a shifter, with no general float-to-integer converter. The table contents are computed with fixed-point integer arithmetic while the design is elaborated, so no file is loaded.

Top module: `act_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is 0x00000000.
- R2: `out_valid` equals the `in_valid` value present at the previous rising clock edge.
- R3: `out_data` loads only on an edge where `in_valid` is 1; on any other edge it keeps its value, whatever `in_data` and `in_func` carry.
- R4: Function code 3'b000 returns the input bit pattern unchanged.
- R5: Function code 3'b001 returns 0x00000000 for every non-NaN input with bit 31 set, including -0.0 (0x80000000) and -inf, and returns every input with bit 31 clear unchanged.
- R6: Under code 3'b001, a NaN (exponent field bits 30:23 all ones and mantissa bits 22:0 nonzero) is returned unchanged, whatever its sign.
- R7: Under code 3'b010, an input x with -4 <= x < +4 selects table entry floor((x + 4) * 32). Every input inside the same 1/32-wide step gives the same output, and this includes subnormals and -0.0.
- R8: Table entry i holds an FP32 value within 0.03 of g(x) = 0.5 x (1 + tanh(0.7978846 (x + 0.044715 x^3))), where x = (i - 128) / 32. Entry 128 (x = 0) is exactly 0x00000000.
- R9: Under code 3'b010, a non-NaN input with bit 31 clear and a value of at least +4.0, including +inf, is returned unchanged.
- R10: Under code 3'b010, a non-NaN input below -4.0, including -inf, returns 0x00000000.
- R11: Under code 3'b010, a NaN of either sign is returned unchanged.
- R12: Function codes 3'b011 through 3'b111 behave exactly like 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` and `in_func` in this cycle |
| in_data | input | 32 | FP32 value to process |
| in_func | input | 3 | Function code: 000 pass, 001 rectifier, 010 GeLU, others pass |
| out_valid | output | 1 | `in_valid` delayed by one register |
| out_data | output | 32 | Registered FP32 result |

## Verification
The GeLU path is swept over all 256 step left edges. Each result is compared against a real-valued evaluation of the tanh formula, which shows whether the table contents are right. Each step midpoint is then applied and compared with its left edge, so a floor index that is off by one step, or that rounds on negative inputs, shows up as a mismatch. A fixed set of boundary values is run under all eight function codes to separate the clamp, passthrough and range-class rules from one another. This set covers signed zeros, both infinities, NaNs of both signs, exactly ±4, the value just below -4, the value just under +4, and the smallest subnormals. Dropping `in_valid` between two loads shows whether the output register is held or overwritten.

// File: rtl/act_pkg.sv
package act_pkg;

    typedef enum logic [1:0] {
        FN_PASS,
        FN_RELU,
        FN_GELU
    } act_fn_e;

    typedef enum logic [1:0] {
        RG_INSIDE,
        RG_ABOVE,
        RG_BELOW,
        RG_NAN
    } act_range_e;

    localparam int FP_W      = 32;
    localparam int FIX_FRAC  = 16;

    // Maps the raw 3-bit select onto a function mode; unused codes fall back to passthrough.
    function automatic act_fn_e decode_fn(input logic [2:0] code);
        case (code)
            3'b000:  return FN_PASS;
            3'b001:  return FN_RELU;
            3'b010:  return FN_GELU;
            default: return FN_PASS;
        endcase
    endfunction

    // Table word for entry idx, computed in 16-bit-fraction fixed point.
    // tanh is replaced by the rational form u(27+u^2)/(27+9u^2), clamped at |u| >= 3.
    function automatic logic [FP_W-1:0] gelu_word(input int idx, input int frac_bits);
        longint s;
        longint xq;
        longint x3;
        longint inner;
        longint u;
        longint u2;
        longint t;
        longint g;
        longint mag;
        int     p;
        logic [FP_W-1:0] w;
        s     = longint'(1) << FIX_FRAC;
        xq    = longint'(idx - (4 << frac_bits)) * (longint'(1) << (FIX_FRAC - frac_bits));
        x3    = (((xq * xq) / s) * xq) / s;
        inner = xq + (longint'(2930) * x3) / s;
        u     = (longint'(52290) * inner) / s;
        if (u >= 3 * s) begin
            t = s;
        end else if (u <= -3 * s) begin
            t = -s;
        end else begin
            u2 = (u * u) / s;
            t  = (u * (27 * s + u2)) / (27 * s + 9 * u2);
        end
        g = (xq * (s + t)) / (2 * s);
        w = '0;
        if (g != 0) begin
            mag = (g < 0) ? -g : g;
            p   = 0;
            for (int b = 0; b < 40; b++) begin
                if (mag[b]) p = b;
            end
            w[31]    = (g < 0);
            w[30:23] = 8'(127 + p - FIX_FRAC);
            w[22:0]  = 23'(mag << (23 - p));
        end
        return w;
    endfunction

endpackage

// File: rtl/act_index.sv
module act_index
    import act_pkg::*;
#(
    parameter int FRAC_BITS = 5
) (
    input  logic [31:0]            x,
    output act_range_e             range_cls,
    output logic [FRAC_BITS+2:0]   idx
);

    localparam int IDX_W = FRAC_BITS + 3;
    localparam int HALF  = 4 << FRAC_BITS;
    // Biased-exponent offset: |x| * 2^F = sig >> (150 - F - e)
    localparam int SHIFT_BASE = 150 - FRAC_BITS;

    logic        sgn;
    logic [7:0]  ex;
    logic [22:0] mn;
    logic [23:0] sig;
    int          sh;
    int          whole;
    logic        part;
    int          pos;
    logic        is_nan;
    logic        is_neg4;

    always_comb begin
        sgn     = x[31];
        ex      = x[30:23];
        mn      = x[22:0];
        sig     = {ex != 8'd0, mn};
        sh      = SHIFT_BASE - ((ex == 8'd0) ? 1 : int'(ex));
        whole   = 0;
        part    = 1'b0;
        if (sh >= 24) begin
            part = (sig != 24'd0);
        end else if (sh > 0) begin
            whole = int'(sig >> sh);
            part  = ((sig & ((24'd1 << sh) - 24'd1)) != 24'd0);
        end else begin
            whole = int'(sig);
        end
        // floor for negatives: one step further down when any fraction remains
        pos     = sgn ? (HALF - whole - int'(part)) : (HALF + whole);
        is_nan  = (ex == 8'hFF) && (mn != 23'd0);
        is_neg4 = sgn && (ex == 8'd129) && (mn == 23'd0);

        range_cls = RG_INSIDE;
        idx       = IDX_W'(pos);
        if (is_nan) begin
            range_cls = RG_NAN;
        end else if (ex >= 8'd129) begin
            if (!sgn) begin
                range_cls = RG_ABOVE;
            end else if (is_neg4) begin
                range_cls = RG_INSIDE;
                idx       = '0;
            end else begin
                range_cls = RG_BELOW;
            end
        end
    end

endmodule

// File: rtl/act_gelu_rom.sv
module act_gelu_rom
    import act_pkg::*;
#(
    parameter int FRAC_BITS = 5
) (
    input  logic [FRAC_BITS+2:0] idx,
    output logic [31:0]          word
);

    localparam int DEPTH = 8 << FRAC_BITS;

    logic [31:0] rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [31:0] ENTRY = gelu_word(i, FRAC_BITS);
        assign rom[i] = ENTRY;
    end

    assign word = rom[idx];

endmodule

// File: rtl/act_stage.sv
module act_stage
    import act_pkg::*;
#(
    parameter int FRAC_BITS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic [2:0]  in_func,
    output logic        out_valid,
    output logic [31:0] out_data
);

    localparam int IDX_W = FRAC_BITS + 3;

    act_fn_e          fn;
    act_range_e       rng;
    logic [IDX_W-1:0] lut_idx;
    logic [31:0]      lut_word;
    logic             is_nan;
    logic [31:0]      nxt;

    act_index #(.FRAC_BITS(FRAC_BITS)) u_index (
        .x         (in_data),
        .range_cls (rng),
        .idx       (lut_idx)
    );

    act_gelu_rom #(.FRAC_BITS(FRAC_BITS)) u_rom (
        .idx  (lut_idx),
        .word (lut_word)
    );

    // Output selection
    always_comb begin
        fn     = decode_fn(in_func);
        is_nan = (&in_data[30:23]) && (|in_data[22:0]);
        nxt    = in_data;
        unique case (fn)
            FN_PASS: nxt = in_data;
            FN_RELU: nxt = (in_data[31] && !is_nan) ? 32'h0 : in_data;
            FN_GELU: begin
                unique case (rng)
                    RG_INSIDE: nxt = lut_word;
                    RG_ABOVE:  nxt = in_data;
                    RG_BELOW:  nxt = 32'h0;
                    RG_NAN:    nxt = in_data;
                endcase
            end
            default: nxt = in_data;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt;
            end
        end
    end

endmodule

// File: rtl/act_stage_chk.sv
module act_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic [2:0]  in_func,
    input logic        out_valid,
    input logic [31:0] out_data
);

    logic in_nan;
    logic below_neg4;
    logic at_or_above4;

    assign in_nan       = (&in_data[30:23]) && (|in_data[22:0]);
    assign below_neg4   = in_data[31] && !in_nan &&
                          ((in_data[30:23] > 8'd129) ||
                           ((in_data[30:23] == 8'd129) && (in_data[22:0] != 23'd0)));
    assign at_or_above4 = !in_data[31] && !in_nan && (in_data[30:23] >= 8'd129);

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b000) |=> (out_data == $past(in_data)));

    p_relu_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b001 && in_data[31] && !in_nan) |=> (out_data == 32'h0));

    p_relu_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b001 && !in_data[31]) |=> (out_data == $past(in_data)));

    p_relu_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b001 && in_nan) |=> (out_data == $past(in_data)));

    p_gelu_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b010 && at_or_above4) |=> (out_data == $past(in_data)));

    p_gelu_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b010 && below_neg4) |=> (out_data == 32'h0));

    p_gelu_nan_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func == 3'b010 && in_nan) |=> (out_data == $past(in_data)));

    p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_func >= 3'b011) |=> (out_data == $past(in_data)));

endmodule

bind act_stage act_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_func   (in_func),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_act_stage.sv
`timescale 1ns/1ps
module sim_act_stage;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic [2:0]  in_func;
    logic        out_valid;
    logic [31:0] out_data;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] gel [256];

    act_stage u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_func   (in_func),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [31:0] fp_of(int num, int sh);
        logic [31:0] w;
        int mag;
        int p;
        w = '0;
        if (num == 0) return w;
        mag = (num < 0) ? -num : num;
        p = 0;
        for (int b = 0; b < 31; b++) if (mag[b]) p = b;
        w[31]    = (num < 0);
        w[30:23] = 8'(127 + p - sh);
        w[22:0]  = 23'(mag << (23 - p));
        return w;
    endfunction

    function automatic real to_real(logic [31:0] w);
        real m;
        int  e;
        e = int'(w[30:23]);
        if (e == 0) m = real'(w[22:0]) * (2.0 ** (-149));
        else        m = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return w[31] ? -m : m;
    endfunction

    function automatic real gelu_ref(real x);
        real u;
        real e2;
        u  = 0.7978845608 * (x + 0.044715 * x * x * x);
        e2 = $exp(2.0 * u);
        return 0.5 * x * (1.0 + (e2 - 1.0) / (e2 + 1.0));
    endfunction

    function automatic bit is_nan(logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic v, logic [31:0] d, logic [2:0] f);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        in_func  = f;
        @(posedge clk);
        #1;
    endtask

    logic [31:0] specials [17];

    initial begin
        specials[0]  = 32'h3F800000; specials[1]  = 32'hBF800000;
        specials[2]  = 32'h80000000; specials[3]  = 32'h00000000;
        specials[4]  = 32'h7F800000; specials[5]  = 32'hFF800000;
        specials[6]  = 32'h7FC00000; specials[7]  = 32'hFFC00001;
        specials[8]  = 32'h40800000; specials[9]  = 32'hC0800000;
        specials[10] = 32'hC0800001; specials[11] = 32'h40A00000;
        specials[12] = 32'hC1200000; specials[13] = 32'h00000001;
        specials[14] = 32'h80000001; specials[15] = 32'h3F000000;
        specials[16] = 32'h407FFFFF;

        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_func = '0;
        repeat (3) @(posedge clk);
        #1;
        check32("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        check32("R1 reset out_data", out_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 and R7: sweep every table step
        for (int i = 0; i < 256; i++) begin
            real x;
            real got;
            real ref_v;
            logic [31:0] left_out;
            apply(1'b1, fp_of(i - 128, 5), 3'b010);
            left_out = out_data;
            gel[i] = left_out;
            check32("R2 valid after gelu", {31'd0, out_valid}, 32'd1);
            x     = real'(i - 128) / 32.0;
            got   = to_real(left_out);
            ref_v = gelu_ref(x);
            n_vec++;
            if ((got - ref_v > 0.03) || (ref_v - got > 0.03) || is_nan(left_out)) begin
                n_bad++;
                $display("FAIL R8 entry %0d actual=%f expected=%f", i, got, ref_v);
            end
            apply(1'b1, fp_of(2 * (i - 128) + 1, 6), 3'b010);
            check32($sformatf("R7 midpoint step %0d", i), out_data, left_out);
        end
        check32("R8 entry 128 exact zero", gel[128], 32'h0);

        // Boundary values under all eight codes
        for (int f = 0; f < 8; f++) begin
            for (int k = 0; k < 17; k++) begin
                logic [31:0] d;
                logic [31:0] exp;
                string tag;
                d = specials[k];
                apply(1'b1, d, 3'(f));
                exp = d;
                if (f == 1) begin
                    tag = is_nan(d) ? "R6 relu nan" : "R5 relu";
                    if (d[31] && !is_nan(d)) exp = 32'h0;
                end else if (f == 2) begin
                    real xv;
                    int  ix;
                    xv = to_real(d);
                    if (is_nan(d)) begin
                        tag = "R11 gelu nan";
                    end else if (!d[31] && d[30:23] >= 8'd129) begin
                        tag = "R9 gelu high";
                    end else if (d[31] && d[30:23] >= 8'd129 && d != 32'hC0800000) begin
                        tag = "R10 gelu low";
                        exp = 32'h0;
                    end else begin
                        tag = "R7 gelu index";
                        ix  = 128 + int'($floor(xv * 32.0));
                        exp = gel[ix];
                    end
                end else if (f == 0) begin
                    tag = "R4 pass";
                end else begin
                    tag = "R12 reserved code";
                end
                check32($sformatf("%s code %0d value %h", tag, f, d), out_data, exp);
                check32("R2 valid follows", {31'd0, out_valid}, 32'd1);
            end
        end

        // R3: idle cycles must not disturb the result
        apply(1'b1, 32'h12345678, 3'b000);
        check32("R4 pass load", out_data, 32'h12345678);
        apply(1'b0, 32'hDEADBEEF, 3'b000);
        check32("R2 valid drops", {31'd0, out_valid}, 32'd0);
        check32("R3 hold with new data", out_data, 32'h12345678);
        apply(1'b0, 32'hBF800000, 3'b001);
        check32("R3 hold with new code", out_data, 32'h12345678);
        apply(1'b1, 32'hBF800000, 3'b001);
        check32("R5 relu after idle", out_data, 32'h0);
        check32("R2 valid returns", {31'd0, out_valid}, 32'd1);

        @(negedge clk);
        in_valid = 1'b0;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule